// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block carries out the stack and program-flow operations of an 8-bit processor with a 16-bit address space. It holds the stack pointer and the program counter. It accepts a one-cycle command, then runs the byte-serial memory traffic that the command needs over a byte-wide synchronous memory port. The operations are: saving a register pair, restoring a register pair, subroutine entry (plain or conditional), subroutine exit (plain or conditional), the eight fixed-vector restarts, swapping the H-L pair with the top-of-stack word, loading the program counter from H-L, and loading the stack pointer from H-L.

A decode stage outside the block supplies the operation code, a condition selector, the processor flags, a 16-bit operand (call target or restart number) and a 16-bit pair value. The program counter register is taken to already point past the transfer instruction, so a call or restart saves its current value as the return address. When the sequencer finishes, it raises a one-cycle completion pulse. For a restore or a swap, the word read from the stack is presented on the result output during that pulse.

Top module: `stack_flow_seq`

## Requirements
- R1: After reset the stack pointer equals parameter SP_INIT, the program counter equals PC_INIT, and busy, done and mem_we are all low; mem_we stays low whenever the block is idle.
- R2: A save (cmd_op 0) decrements SP, writes the pair's upper byte there, decrements SP again and writes the lower byte there. SP ends 2 below its start, with 16-bit wrap-around.
- R3: A restore (cmd_op 1) reads the lower byte at SP and the upper byte at SP+1 (read data returns one cycle after the address). pair_out holds {upper, lower} at done, and SP ends 2 above its start.
- R4: A call (cmd_op 2) that is taken saves the current PC as in R2 and then loads PC with cmd_operand.
- R5: A return (cmd_op 3) that is taken restores a word as in R3 and loads it into PC.
- R6: When cmd_cond_en is 1, a call or return is taken only if its condition holds. cmd_flags is {S,Z,P,CY} (bit 3 down to bit 0), and cmd_cond codes 0..7 test CY=1, CY=0, S=0, S=1, Z=1, Z=0, P=1 and P=0. When cmd_cond_en is 0 the call or return is always taken.
- R7: A call or return whose condition fails makes no memory access, leaves SP and PC unchanged, and completes one cycle after acceptance.
- R8: A restart (cmd_op 4) with number n = cmd_operand[2:0] saves the current PC as in R2 and loads PC with n*8.
- R9: A swap (cmd_op 5) exchanges cmd_pair[7:0] with the byte at SP and cmd_pair[15:8] with the byte at SP+1. SP is unchanged, and pair_out shows the old stack word at done.
- R10: cmd_op 6 loads PC with cmd_pair (high byte H, low byte L) with no memory access.
- R11: cmd_op 7 loads SP with cmd_pair with no memory access.
- R12: done is high for exactly one cycle. Counted in cycles after the accepting clock edge, done is seen after 1 cycle for cmd_op 6, cmd_op 7 and skipped transfers, after 3 for a save, call or restart, after 4 for a restore or return, and after 5 for a swap.
- R13: A command presented while busy is high, including the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Operation code (0 save, 1 restore, 2 call, 3 return, 4 restart, 5 swap, 6 PC load, 7 SP load) |
| cmd_cond_en | input | 1 | 1 makes call/return conditional |
| cmd_cond | input | 3 | Condition selector |
| cmd_flags | input | 4 | Flags {S,Z,P,CY} |
| cmd_operand | input | 16 | Call target or restart number |
| cmd_pair | input | 16 | Register pair value (H-L for swap and loads) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pair_out | output | 16 | Word read from the stack |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |

## Verification
Directed sequences pair each save with a restore and each call with a return. This shows that the byte order and the pre-decrement and post-increment of SP agree, not only that each one is self-consistent. All eight condition codes are swept against all sixteen flag combinations, so a swapped polarity or a wrong flag bit shows up as a taken/skipped mismatch. A stack pointer near zero exercises wrap-around, and commands injected mid-operation and in the done cycle show whether the busy gate holds. Random operations with random flags, operands and pair values then run against a shadow memory in the bench, and this catches crossed byte lanes in the swap and stale return addresses.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PW = 2 * DW;
  localparam int CW = 3;
  localparam int RST_SHIFT = 3;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RST   = 3'd4,
    OP_SWAP  = 3'd5,
    OP_JMPHL = 3'd6,
    OP_LDSP  = 3'd7
  } sfs_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PSH_HI,
    ST_PSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_TL,
    ST_SW_RDL,
    ST_SW_RDH,
    ST_SW_WRL,
    ST_SW_WRH,
    ST_FIN
  } sfs_state_e;

  typedef struct packed {
    logic s;
    logic z;
    logic p;
    logic cy;
  } sfs_flags_t;

  function automatic logic cond_hit(input logic [CW-1:0] code, input sfs_flags_t f);
    logic hit;
    case (code)
      3'd0: hit = f.cy;
      3'd1: hit = !f.cy;
      3'd2: hit = !f.s;
      3'd3: hit = f.s;
      3'd4: hit = f.z;
      3'd5: hit = !f.z;
      3'd6: hit = f.p;
      default: hit = !f.p;
    endcase
    return hit;
  endfunction

  function automatic logic [AW-1:0] restart_vec(input logic [CW-1:0] n);
    return AW'({n, {RST_SHIFT{1'b0}}});
  endfunction

  function automatic logic [AW-1:0] step_dn(input logic [AW-1:0] v);
    return v - AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  function automatic logic uses_cond(input sfs_op_e op);
    return (op == OP_CALL) || (op == OP_RET);
  endfunction

endpackage

// File: rtl/sfs_cond.sv
module sfs_cond
  import sfs_pkg::*;
(
  input  logic [CW-1:0] code,
  input  logic [3:0]    flags,
  input  logic          cond_en,
  output logic          take
);

  sfs_flags_t fl;

  assign fl   = sfs_flags_t'(flags);
  assign take = !cond_en || cond_hit(code, fl);

endmodule

// File: rtl/sfs_port.sv
module sfs_port
  import sfs_pkg::*;
(
  input  sfs_state_e    state,
  input  logic [AW-1:0] sp,
  input  logic [PW-1:0] wr_word,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          stack_touch
);

  always_comb begin
    addr        = '0;
    wdata       = '0;
    we          = 1'b0;
    stack_touch = 1'b1;
    case (state)
      ST_PSH_HI: begin
        addr  = step_dn(sp);
        wdata = wr_word[PW-1:DW];
        we    = 1'b1;
      end
      ST_PSH_LO: begin
        addr  = step_dn(sp);
        wdata = wr_word[DW-1:0];
        we    = 1'b1;
      end
      ST_POP_LO, ST_POP_HI: addr = sp;
      ST_SW_RDL: addr = sp;
      ST_SW_RDH: addr = step_up(sp);
      ST_SW_WRL: begin
        addr  = sp;
        wdata = wr_word[DW-1:0];
        we    = 1'b1;
      end
      ST_SW_WRH: begin
        addr  = step_up(sp);
        wdata = wr_word[PW-1:DW];
        we    = 1'b1;
      end
      default: stack_touch = 1'b0;
    endcase
  end

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT = 16'hFFF0,
  parameter logic [AW-1:0] PC_INIT = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  sfs_op_e       cmd_op,
  input  logic [AW-1:0] cmd_operand,
  input  logic [PW-1:0] cmd_pair,
  input  logic          take,
  input  logic [DW-1:0] mem_rdata,
  output sfs_state_e    state,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] pc,
  output logic [PW-1:0] wr_word,
  output logic [PW-1:0] result,
  output logic          accept,
  output logic          skip
);

  sfs_op_e       op_q;
  logic [AW-1:0] tgt;
  logic [DW-1:0] res_lo;
  logic [DW-1:0] res_hi;

  assign accept = cmd_valid && (state == ST_IDLE);
  assign skip   = accept && uses_cond(cmd_op) && !take;
  assign result = {res_hi, res_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sp      <= SP_INIT;
      pc      <= PC_INIT;
      op_q    <= OP_PUSH;
      tgt     <= '0;
      wr_word <= '0;
      res_lo  <= '0;
      res_hi  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q <= cmd_op;
            if (skip) begin
              state <= ST_FIN;
            end else begin
              case (cmd_op)
                OP_PUSH: begin
                  wr_word <= cmd_pair;
                  state   <= ST_PSH_HI;
                end
                OP_CALL: begin
                  wr_word <= PW'(pc);
                  tgt     <= cmd_operand;
                  state   <= ST_PSH_HI;
                end
                OP_RST: begin
                  wr_word <= PW'(pc);
                  tgt     <= restart_vec(cmd_operand[CW-1:0]);
                  state   <= ST_PSH_HI;
                end
                OP_POP, OP_RET: state <= ST_POP_LO;
                OP_SWAP: begin
                  wr_word <= cmd_pair;
                  state   <= ST_SW_RDL;
                end
                OP_JMPHL: begin
                  pc    <= AW'(cmd_pair);
                  state <= ST_FIN;
                end
                default: begin
                  sp    <= AW'(cmd_pair);
                  state <= ST_FIN;
                end
              endcase
            end
          end
        end
        ST_PSH_HI: begin
          sp    <= step_dn(sp);
          state <= ST_PSH_LO;
        end
        ST_PSH_LO: begin
          sp <= step_dn(sp);
          if (op_q != OP_PUSH) pc <= tgt;
          state <= ST_FIN;
        end
        ST_POP_LO: begin
          sp    <= step_up(sp);
          state <= ST_POP_HI;
        end
        ST_POP_HI: begin
          res_lo <= mem_rdata;
          sp     <= step_up(sp);
          state  <= ST_POP_TL;
        end
        ST_POP_TL: begin
          res_hi <= mem_rdata;
          if (op_q == OP_RET) pc <= AW'({mem_rdata, res_lo});
          state <= ST_FIN;
        end
        ST_SW_RDL: state <= ST_SW_RDH;
        ST_SW_RDH: begin
          res_lo <= mem_rdata;
          state  <= ST_SW_WRL;
        end
        ST_SW_WRL: begin
          res_hi <= mem_rdata;
          state  <= ST_SW_WRH;
        end
        ST_SW_WRH: state <= ST_FIN;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stack_flow_seq.sv
module stack_flow_seq
  import sfs_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT = 16'hFFF0,
  parameter logic [AW-1:0] PC_INIT = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_cond_en,
  input  logic [2:0]    cmd_cond,
  input  logic [3:0]    cmd_flags,
  input  logic [15:0]   cmd_operand,
  input  logic [15:0]   cmd_pair,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   pair_out,
  output logic [15:0]   sp_out,
  output logic [15:0]   pc_out
);

  sfs_op_e       op_in;
  sfs_state_e    state;
  logic          take;
  logic          accept;
  logic          skip;
  logic          stack_touch;
  logic [AW-1:0] sp;
  logic [AW-1:0] pc;
  logic [PW-1:0] wr_word;
  logic [PW-1:0] result;

  assign op_in = sfs_op_e'(cmd_op);

  sfs_cond u_cond (
    .code    (cmd_cond),
    .flags   (cmd_flags),
    .cond_en (cmd_cond_en),
    .take    (take)
  );

  sfs_ctrl #(
    .SP_INIT (SP_INIT),
    .PC_INIT (PC_INIT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (op_in),
    .cmd_operand (cmd_operand),
    .cmd_pair    (cmd_pair),
    .take        (take),
    .mem_rdata   (mem_rdata),
    .state       (state),
    .sp          (sp),
    .pc          (pc),
    .wr_word     (wr_word),
    .result      (result),
    .accept      (accept),
    .skip        (skip)
  );

  sfs_port u_port (
    .state       (state),
    .sp          (sp),
    .wr_word     (wr_word),
    .addr        (mem_addr),
    .wdata       (mem_wdata),
    .we          (mem_we),
    .stack_touch (stack_touch)
  );

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign pair_out = result;
  assign sp_out   = sp;
  assign pc_out   = pc;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import sfs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [15:0] cmd_pair,
  input logic        accept,
  input logic        skip,
  input logic        take,
  input logic        stack_touch,
  input logic        mem_we,
  input logic        busy,
  input logic        done,
  input logic [15:0] sp_out,
  input logic [15:0] pc_out
);

  logic [15:0] start_sp;
  logic [2:0]  opk;
  logic        tk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_sp <= '0;
      opk      <= '0;
      tk       <= 1'b0;
    end else if (accept) begin
      start_sp <= sp_out;
      opk      <= cmd_op;
      tk       <= take;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && (opk == 3'd0 || opk == 3'd4 || (opk == 3'd2 && tk))
      |-> sp_out == 16'(start_sp - 16'd2));

  p_pop_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && (opk == 3'd1 || (opk == 3'd3 && tk))
      |-> sp_out == 16'(start_sp + 16'd2));

  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> done && !stack_touch && sp_out == $past(sp_out) && pc_out == $past(pc_out));

  p_swap_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && opk == 3'd5 |-> sp_out == start_sp);

  p_pc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == 3'd6 |=> done && !stack_touch && pc_out == $past(cmd_pair));

  p_done_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmd_valid |=> !busy);

endmodule

bind stack_flow_seq sfs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_pair    (cmd_pair),
  .accept      (accept),
  .skip        (skip),
  .take        (take),
  .stack_touch (stack_touch),
  .mem_we      (mem_we),
  .busy        (busy),
  .done        (done),
  .sp_out      (sp_out),
  .pc_out      (pc_out)
);

// File: tb/stack_flow_seq_bench.sv
`timescale 1ns/1ps
module stack_flow_seq_bench;

  localparam logic [15:0] B_SP0 = 16'h80F0;
  localparam logic [15:0] B_PC0 = 16'h0100;
  localparam logic [2:0] K_PUSH = 3'd0, K_POP = 3'd1, K_CALL = 3'd2, K_RET = 3'd3,
                         K_RST = 3'd4, K_SWAP = 3'd5, K_JHL = 3'd6, K_LSP = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_cond_en = 1'b0;
  logic [2:0] cmd_cond = '0;
  logic [3:0] cmd_flags = '0;
  logic [15:0] cmd_operand = '0;
  logic [15:0] cmd_pair = '0;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we;
  logic [7:0] mem_rdata;
  logic busy, done;
  logic [15:0] pair_out, sp_out, pc_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [7:0] ram [256];
  logic [7:0] shadow [256];
  logic [15:0] exp_sp = B_SP0;
  logic [15:0] exp_pc = B_PC0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  stack_flow_seq #(.SP_INIT(B_SP0), .PC_INIT(B_PC0)) u_stack_flow_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond_en(cmd_cond_en), .cmd_cond(cmd_cond), .cmd_flags(cmd_flags),
    .cmd_operand(cmd_operand), .cmd_pair(cmd_pair), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pair_out(pair_out), .sp_out(sp_out), .pc_out(pc_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // condition test restated as a flag pick plus a wanted level
  function automatic bit b_cond(input logic [2:0] cc, input logic [3:0] fl);
    logic [1:0] grp;
    logic f;
    logic want;
    grp  = cc[2:1];
    f    = (grp == 2'd0) ? fl[0] : (grp == 2'd1) ? fl[3] : (grp == 2'd2) ? fl[2] : fl[1];
    want = cc[0] ^ (grp != 2'd1);
    return f == want;
  endfunction

  task automatic m_push(input logic [15:0] w);
    exp_sp = exp_sp - 16'd1;
    shadow[exp_sp[7:0]] = w[15:8];
    exp_sp = exp_sp - 16'd1;
    shadow[exp_sp[7:0]] = w[7:0];
  endtask

  function automatic logic [15:0] m_top();
    logic [15:0] a;
    a = exp_sp + 16'd1;
    return {shadow[a[7:0]], shadow[exp_sp[7:0]]};
  endfunction

  task automatic do_op(input logic [2:0] op, input logic cen, input logic [2:0] cc,
                       input logic [3:0] fl, input logic [15:0] opnd, input logic [15:0] pr,
                       input int inj, input string req);
    bit tk;
    int exp_lat;
    int lat;
    bit chk_pair;
    logic [15:0] exp_pair;
    logic [15:0] a1;
    int mism;
    tk = ((op == K_CALL) || (op == K_RET)) ? (!cen || b_cond(cc, fl)) : 1'b1;
    chk_pair = 1'b0;
    exp_pair = '0;
    exp_lat = 1;
    if (tk) begin
      case (op)
        K_PUSH: begin m_push(pr); exp_lat = 3; end
        K_CALL: begin m_push(exp_pc); exp_pc = opnd; exp_lat = 3; end
        K_RST:  begin m_push(exp_pc); exp_pc = {10'd0, opnd[2:0], 3'd0}; exp_lat = 3; end
        K_POP, K_RET: begin
          exp_pair = m_top();
          chk_pair = 1'b1;
          exp_sp = exp_sp + 16'd2;
          if (op == K_RET) exp_pc = exp_pair;
          exp_lat = 4;
        end
        K_SWAP: begin
          exp_pair = m_top();
          chk_pair = 1'b1;
          a1 = exp_sp + 16'd1;
          shadow[exp_sp[7:0]] = pr[7:0];
          shadow[a1[7:0]] = pr[15:8];
          exp_lat = 5;
        end
        K_JHL: exp_pc = pr;
        default: exp_sp = pr;
      endcase
    end
    @(negedge clk);
    cmd_op = op; cmd_cond_en = cen; cmd_cond = cc; cmd_flags = fl;
    cmd_operand = opnd; cmd_pair = pr; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 16) begin
      if (inj != 0 && lat == inj) begin
        cmd_valid = 1'b1; cmd_op = K_JHL; cmd_pair = 16'hDEAD;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      lat++;
    end
    chk(lat == exp_lat, "R12", "latency", lat, exp_lat);
    chk(sp_out == exp_sp, req, "sp", sp_out, exp_sp);
    chk(pc_out == exp_pc, req, "pc", pc_out, exp_pc);
    if (chk_pair) chk(pair_out == exp_pair, req, "pair_out", pair_out, exp_pair);
    mism = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== shadow[i]) mism++;
    chk(mism == 0, req, "stack bytes mismatching", mism, 0);
    if (inj != 0) begin
      cmd_valid = 1'b1; cmd_op = K_JHL; cmd_pair = 16'hBEEF;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!done, "R12", "done second cycle", done, 0);
    if (inj != 0) begin
      chk(!busy, "R13", "busy after ignored cmd", busy, 0);
      chk(pc_out == exp_pc, "R13", "pc after ignored cmd", pc_out, exp_pc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0000_5EED);
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp_out == B_SP0, "R1", "sp reset", sp_out, B_SP0);
    chk(pc_out == B_PC0, "R1", "pc reset", pc_out, B_PC0);
    chk(!busy && !done && !mem_we, "R1", "busy/done/we", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(K_PUSH, 0, 0, 0, 0, 16'hA1B2, 0, "R2");
    do_op(K_POP,  0, 0, 0, 0, 0, 0, "R3");
    do_op(K_CALL, 0, 0, 0, 16'h1234, 0, 0, "R4");
    do_op(K_RET,  0, 0, 0, 0, 0, 0, "R5");

    for (int cc = 0; cc < 8; cc++) begin
      for (int fl = 0; fl < 16; fl++) begin
        do_op(K_CALL, 1, 3'(cc), 4'(fl), 16'h2000 + 16'(fl), 0, 0,
              b_cond(3'(cc), 4'(fl)) ? "R6" : "R7");
        do_op(K_RET, 1, 3'(cc), 4'(fl), 0, 0, 0,
              b_cond(3'(cc), 4'(fl)) ? "R6" : "R7");
      end
    end

    for (int n = 0; n < 8; n++) begin
      do_op(K_JHL, 0, 0, 0, 0, 16'h4000 + 16'(n), 0, "R10");
      do_op(K_RST, 0, 0, 0, 16'hFFF8 | 16'(n), 0, 0, "R8");
    end
    do_op(K_LSP,  0, 0, 0, 0, 16'h8050, 0, "R11");
    do_op(K_PUSH, 0, 0, 0, 0, 16'h1357, 0, "R2");
    do_op(K_SWAP, 0, 0, 0, 0, 16'hC3D4, 0, "R9");
    do_op(K_POP,  0, 0, 0, 0, 0, 0, "R9");
    // wrap-around of SP
    do_op(K_LSP,  0, 0, 0, 0, 16'h0001, 0, "R11");
    do_op(K_PUSH, 0, 0, 0, 0, 16'h5AA5, 0, "R2");
    do_op(K_POP,  0, 0, 0, 0, 0, 0, "R3");
    // commands while busy
    do_op(K_PUSH, 0, 0, 0, 0, 16'h0F0F, 2, "R13");
    do_op(K_SWAP, 0, 0, 0, 0, 16'h7788, 3, "R13");
    do_op(K_RET,  0, 0, 0, 0, 0, 1, "R13");

    for (int k = 0; k < 300; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      do_op(op, 1'($urandom), 3'($urandom), 4'($urandom), 16'($urandom), 16'($urandom), 0,
            op == K_PUSH ? "R2" : op == K_POP ? "R3" : op == K_CALL ? "R4" :
            op == K_RET ? "R5" : op == K_RST ? "R8" : op == K_SWAP ? "R9" :
            op == K_JHL ? "R10" : "R11");
    end
    finish_run();
  end

endmodule